// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external processor read and write a 256-entry, byte-wide register space over a four-wire serial link. The link runs in clock mode 0. The master drives data on the falling edge of the serial clock and samples it on the rising edge. The select line is active low. Inside the chip the block drives a plain register-file port: an address, write data, a write strobe, and read data that returns one clock after the address.

Every transaction opens with a command byte and then an address byte. Data bytes follow, and each one reaches the next register in sequence until select goes high. All bytes travel most significant bit first. Code 0x02 selects a write and code 0x03 selects a read. Any other command code makes the block ignore the rest of the transaction.

The serial clock may run at up to 25 MHz. The block samples the serial clock and select with its own, much faster system clock. There are no clocks derived from the serial clock. The data output carries an enable that stays low while select is high, so a pad can tri-state the line.

Top module: `spi_regport`

## Requirements
- R1: Each frame is one command byte, then one address byte, then data bytes. Every byte is shifted most significant bit first and sampled on rising serial-clock edges.
- R2: After command 0x02, each completed data byte raises `reg_we` for exactly one system clock. During that clock, `reg_wdata` holds the byte and `reg_addr` holds its target register.
- R3: After command 0x03, the content of the addressed register appears on `spi_miso` MSB first, bit 7 ready before the first rising edge of the first data byte. The register port has one clock of read latency.
- R4: Within a burst, successive data bytes (read or write) use consecutive register addresses, starting at the address byte.
- R5: The register address wraps from 0xFF to 0x00 inside a burst.
- R6: Any command byte other than 0x02 or 0x03 causes no write until select rises, and `spi_miso` stays 0.
- R7: If select rises before a byte is complete, that byte is dropped with no write. The next frame starts again with a command byte.
- R8: `spi_miso_oe` is 0 within four system clocks of select rising and stays 0 while select is high. It is 1 within four clocks of select falling.
- R9: While reset is high and right after it, `reg_we`, `spi_miso_oe` and `reg_addr` are 0.
- R10: Serial-clock edges while select is high have no effect on the frame that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Select from the master, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| reg_addr | output | 8 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe, one clock per byte |
| reg_rdata | input | 8 | Register-file read data, valid one clock after `reg_addr` |

## Verification
The bench runs bursts that start at 0xFE. A pointer that saturates, or that fails to wrap, writes or reads the wrong registers at the top of the space. It reads back a byte of 0x01, which exposes a design that shifts LSB first. It starts a read immediately after its address byte, which catches a prefetch that arrives late and sends a stale or zero first bit. It also cuts a byte short by raising select mid-byte, sends an unknown command, and toggles the serial clock while idle. A design that wrote a partial byte, honoured the unknown command, or counted idle edges would produce extra or misplaced writes, and the write-queue comparison flags these.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_WADDR,
    PH_RADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign level = stg[STAGES-1];
endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         sck,
  input  logic         mosi,
  output logic         byte_done,
  output logic [W-1:0] byte_q,
  output logic         mid_byte,
  output logic         sck_fall
);
  localparam int CW = $clog2(W);

  logic          sck_d;
  logic          sck_rise;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr;

  assign sck_rise = sck & ~sck_d;
  assign sck_fall = ~sck & sck_d;
  assign mid_byte = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt       <= '0;
      sr        <= '0;
      byte_done <= 1'b0;
      if (rst) byte_q <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        sr <= {sr[W-2:0], mosi};
        if (cnt == CW'(W-1)) begin
          cnt       <= '0;
          byte_done <= 1'b1;
          byte_q    <= {sr[W-2:0], mosi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: a dropped select clears any partial byte
  p_abort_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!mid_byte && !byte_done));

  // R1: a byte takes several serial clocks, so completions never touch
  p_done_gap_r1: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_WR = 8'h02,
  parameter logic [DATA_W-1:0] CMD_RD = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              mid_byte,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              miso,
  output logic              miso_oe
);
  phase_t            ph;
  logic [ADDR_W-1:0] ptr;
  logic              fetch1, fetch2;
  logic [DATA_W-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_CMD;
      ptr       <= '0;
      fetch1    <= 1'b0;
      fetch2    <= 1'b0;
      tx        <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      miso_oe   <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      fetch1  <= 1'b0;
      fetch2  <= fetch1 & active;
      miso_oe <= active;
      if (reg_we) ptr <= ptr + 1'b1;
      if (fetch2)
        tx <= reg_rdata;
      else if (sck_fall && mid_byte)
        tx <= {tx[DATA_W-2:0], 1'b0};
      if (!active) begin
        ph <= PH_CMD;
        tx <= '0;
      end else if (byte_done) begin
        unique case (ph)
          PH_CMD: begin
            if (byte_in == CMD_WR)      ph <= PH_WADDR;
            else if (byte_in == CMD_RD) ph <= PH_RADDR;
            else                        ph <= PH_SKIP;
          end
          PH_WADDR: begin
            ptr <= byte_in[ADDR_W-1:0];
            ph  <= PH_WDATA;
          end
          PH_RADDR: begin
            ptr    <= byte_in[ADDR_W-1:0];
            fetch1 <= 1'b1;
            ph     <= PH_RDATA;
          end
          PH_WDATA: begin
            reg_we    <= 1'b1;
            reg_wdata <= byte_in;
          end
          PH_RDATA: begin
            ptr    <= ptr + 1'b1;
            fetch1 <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr = ptr;
  assign miso     = tx[DATA_W-1];

  // R2: one strobe per byte
  p_we_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4 / R5: after a write the pointer moves to the next register, wrapping
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

  // R6: an unknown command never writes
  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SKIP) |-> !reg_we);

  // R6: output stays low in an ignored frame
  p_skip_low_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SKIP) |=> !miso);
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CMD_WR = 8'h02,
  parameter logic [DATA_W-1:0] CMD_RD = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int IX_MOSI = 0;
  localparam int IX_SCK  = 1;
  localparam int IX_CSN  = 2;
  localparam int NSIG    = 3;

  logic [NSIG-1:0]   lvl;
  logic              active;
  logic              byte_done;
  logic [DATA_W-1:0] byte_q;
  logic              mid_byte;
  logic              sck_fall;

  spi_regport_sync #(
    .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(NSIG'(1) << IX_CSN)
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({spi_csn, spi_sck, spi_mosi}),
    .level(lvl)
  );

  assign active = ~lvl[IX_CSN];

  spi_regport_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active),
    .sck(lvl[IX_SCK]), .mosi(lvl[IX_MOSI]),
    .byte_done(byte_done), .byte_q(byte_q),
    .mid_byte(mid_byte), .sck_fall(sck_fall)
  );

  spi_regport_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .active(active),
    .byte_done(byte_done), .byte_in(byte_q),
    .mid_byte(mid_byte), .sck_fall(sck_fall),
    .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // R8: a select held high for four clocks turns the output driver off
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |=> !spi_miso_oe);

  // R10: with select high no write can start
  p_idle_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |=> !reg_we);
endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  int checks = 0, errors = 0, we_count = 0;
  logic [15:0] wq[$];
  logic [7:0]  mem [256];
  logic [7:0]  expm [256];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // register file model: one clock of read latency
  initial for (int i = 0; i < 256; i++) begin
    mem[i]  = 8'((i * 7 + 3) ^ 8'h5A);
    expm[i] = mem[i];
  end
  always @(posedge clk) begin
    reg_rdata <= mem[reg_addr];
    if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  // per-clock reference comparison
  int   csn_run = 0;
  logic csn_last = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_csn == csn_last) csn_run++; else csn_run = 1;
      csn_last = spi_csn;
      if (csn_run >= 4) chk(spi_miso_oe == !spi_csn, "R8 oe", spi_miso_oe, !spi_csn);
      if (reg_we) begin
        we_count++;
        if (wq.size() == 0) chk(1'b0, "R2 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = wq.pop_front();
          chk({reg_addr, reg_wdata} == e, "R2/R4 write addr,data", {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      #20;
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      #20;
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    spi_csn = 1'b0;
    #40;
  endtask

  task automatic cs_off();
    #20;
    spi_csn = 1'b1;
    #80;
  endtask

  task automatic wr_burst(input logic [7:0] a, input int n, input logic [7:0] base);
    logic [7:0] rx;
    cs_on();
    sbyte(8'h02, rx);
    sbyte(a, rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] ad, d;
      ad = a + 8'(k);
      d  = base + 8'(k * 17);
      wq.push_back({ad, d});
      expm[ad] = d;
      sbyte(d, rx);
    end
    cs_off();
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n, input string req);
    logic [7:0] rx;
    cs_on();
    sbyte(8'h03, rx);
    sbyte(a, rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] ad;
      ad = a + 8'(k);
      sbyte(8'h00, rx);
      chk(rx == expm[ad], req, rx, expm[ad]);
    end
    cs_off();
  endtask

  initial begin
    int w0;
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(reg_we == 1'b0, "R9 we in reset", reg_we, 0);
    chk(spi_miso_oe == 1'b0, "R9 oe in reset", spi_miso_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_addr == 8'h00, "R9 addr after reset", reg_addr, 0);
    chk(reg_we == 1'b0, "R9 we after reset", reg_we, 0);
    repeat (4) @(negedge clk);

    // R1/R2 single writes with asymmetric patterns, then R3 read back
    wr_burst(8'h10, 1, 8'hA5);
    wr_burst(8'h40, 1, 8'h01);
    chk(wq.size() == 0, "R2 writes delivered", wq.size(), 0);
    rd_burst(8'h40, 1, "R1 msb-first read");
    rd_burst(8'h10, 1, "R3 single read");

    // R4 burst and R5 wrap
    wr_burst(8'h80, 3, 8'h3C);
    wr_burst(8'hFE, 4, 8'hC1);
    rd_burst(8'h80, 3, "R4 burst read");
    rd_burst(8'hFE, 4, "R5 wrap read");
    rd_burst(8'h7F, 3, "R3 untouched neighbours");

    // R6 unknown command: no write, output low
    w0 = we_count;
    cs_on();
    sbyte(8'h55, rx);
    sbyte(8'h30, rx);
    chk(rx == 8'h00, "R6 miso low", rx, 0);
    sbyte(8'hEE, rx);
    chk(rx == 8'h00, "R6 miso low", rx, 0);
    sbyte(8'h77, rx);
    cs_off();
    chk(we_count == w0, "R6 no write", we_count, w0);
    rd_burst(8'h30, 2, "R6 registers unchanged");

    // R7 abort mid-byte
    w0 = we_count;
    cs_on();
    sbyte(8'h02, rx);
    sbyte(8'h60, rx);
    wq.push_back({8'h60, 8'h77});
    expm[8'h60] = 8'h77;
    sbyte(8'h77, rx);
    for (int i = 0; i < 4; i++) begin
      spi_mosi = 1'b1; #20; spi_sck = 1'b1; #20; spi_sck = 1'b0;
    end
    cs_off();
    chk(we_count == w0 + 1, "R7 partial byte not written", we_count, w0 + 1);
    rd_burst(8'h60, 2, "R7 next frame starts fresh");

    // R10 idle clock edges
    w0 = we_count;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      spi_mosi = i[0]; #20; spi_sck = 1'b1; #20; spi_sck = 1'b0;
    end
    #40;
    chk(we_count == w0, "R10 idle edges no write", we_count, w0);
    wr_burst(8'h21, 2, 8'h96);
    rd_burst(8'h21, 2, "R10 frame aligned after idle edges");

    chk(wq.size() == 0, "R2 all writes seen", wq.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule